// File: doc/BRIEF.md
# Microframe Index and SOF Number Counter

This block keeps the host's running count of 125 µs microframes. Each pulse on the microframe tick, taken while the controller is running, moves a 14-bit index forward by one. Three views of that count leave the block. The first is the whole index in a 32-bit register image. The second is a 10-bit slot number that the periodic schedule uses to pick one of 1024 list entries. The third is an 11-bit start-of-frame number from which the token sender builds SOF packets.

The SOF number is a shadow counter of its own. It moves only when the low three index bits go from 000b to 001b, which is once per 1 ms frame, so the index stays one microframe ahead of the number on the bus. Software may rewrite the index only while the controller reports halted. Such a write also copies index bits 13:3 into the shadow in the same cycle, which keeps the two views consistent. Software never loads an index that ends in 000b or 111b, so the load path handles no special case for those values.

Top module: `mfidx_top`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the index and the SOF number to zero, so every output reads zero.
- R2: When tick_i is high while run_i=1 and halted_i=0, the index shows its old value plus one after that clock edge.
- R3: The index wraps from 0x3FFF to 0x0000 on an advance.
- R4: list_slot_o always equals index bits 12:3, so each slot stays selected for eight consecutive microframes.
- R5: The SOF number goes up by one only on an advance that takes the low three index bits from 000b to 001b, and it wraps from 0x7FF to 0x000. Any other advance leaves it unchanged.
- R6: A write is accepted when reg_wr_i=1, all four reg_be_i bits are 1, halted_i=1 and run_i=0. On the next edge the index takes reg_wdata_i[13:0] and the SOF number takes reg_wdata_i[13:3].
- R7: A write made while run_i=1, or while halted_i=0, leaves both the index and the SOF number unchanged.
- R8: A write with any reg_be_i bit at 0 leaves both counters unchanged.
- R9: reg_rdata_o shows the index in bits 13:0 and reads zero in bits 31:14. Bits 31:14 of a write are discarded.
- R10: tick_i has no effect while run_i=0 or halted_i=1.
- R11: Starting from reset and advancing by ticks alone, the SOF number equals index[13:3] plus one whenever index[2:0] is not 000b, and equals index[13:3] otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse marking the end of a microframe |
| run_i | input | 1 | Controller run indication |
| halted_i | input | 1 | Controller halted indication |
| reg_wr_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Register image of the index |
| uf_idx_o | output | 14 | Current microframe index |
| list_slot_o | output | 10 | Periodic list slot (index bits 12:3) |
| sof_num_o | output | 11 | SOF number shadow |

## Verification
A microframe tick and a register write can reach the block in the same cycle. The bench drives both together in each controller state. While halted, the bench expects the write to load both counters and the tick to be dropped. While running, it expects the tick to advance the index by one and the write to be refused, with the SOF number judged by the 000b-to-001b rule. The checker also proves on every edge that the advance and load paths never disturb the counters in any other way.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;

   localparam int unsigned DEF_IDX_W = 14;
   localparam int unsigned DEF_SUB_W = 3;
   localparam int unsigned DEF_REG_W = 32;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_ADV  = 2'd1,
      CMD_LOAD = 2'd2
   } mf_cmd_e;

endpackage

// File: rtl/mfidx_ctl.sv
module mfidx_ctl
   import mfidx_pkg::*;
#(
   parameter int unsigned REG_W = DEF_REG_W,
   parameter int unsigned IDX_W = DEF_IDX_W,
   localparam int unsigned BE_W = REG_W / 8
) (
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             halted_i,
   input  logic             wr_i,
   input  logic [BE_W-1:0]  be_i,
   input  logic [REG_W-1:0] wdata_i,
   output mf_cmd_e          cmd_o,
   output logic [IDX_W-1:0] load_val_o
);

   logic [BE_W-1:0] lane_ok;
   logic            full_word;
   logic            may_write;
   logic            may_count;

   // each byte lane must be enabled for a write to count as whole
   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_ok[g] = be_i[g];
   end

   assign full_word = &lane_ok;
   assign may_write = halted_i & ~run_i;
   assign may_count = run_i & ~halted_i;

   always_comb begin
      cmd_o = CMD_IDLE;
      if (wr_i && full_word && may_write) begin
         cmd_o = CMD_LOAD;
      end else if (tick_i && may_count) begin
         cmd_o = CMD_ADV;
      end
   end

   assign load_val_o = wdata_i[IDX_W-1:0];

   if (REG_W > IDX_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[REG_W-1:IDX_W];
   end

endmodule

// File: rtl/mfidx_index_ctr.sv
module mfidx_index_ctr
   import mfidx_pkg::*;
#(
   parameter int unsigned IDX_W = DEF_IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mf_cmd_e          cmd_i,
   input  logic [IDX_W-1:0] load_val_i,
   output logic [IDX_W-1:0] idx_o
);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_d;

   always_comb begin
      unique case (cmd_i)
         CMD_ADV:  idx_d = idx_q + 1'b1;
         CMD_LOAD: idx_d = load_val_i;
         default:  idx_d = idx_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx_d;
   end

   assign idx_o = idx_q;

endmodule

// File: rtl/mfidx_sof_shadow.sv
module mfidx_sof_shadow
   import mfidx_pkg::*;
#(
   parameter int unsigned IDX_W = DEF_IDX_W,
   parameter int unsigned SUB_W = DEF_SUB_W,
   localparam int unsigned SOF_W = IDX_W - SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mf_cmd_e          cmd_i,
   input  logic [SUB_W-1:0] idx_low_i,
   input  logic [SOF_W-1:0] load_hi_i,
   output logic [SOF_W-1:0] sof_o
);

   logic [SOF_W-1:0] sof_q;
   logic [SOF_W-1:0] sof_d;
   logic             frame_edge;

   // an advance taken from sub-count zero is the 000 -> 001 transition
   assign frame_edge = (cmd_i == CMD_ADV) && (idx_low_i == '0);

   always_comb begin
      sof_d = sof_q;
      if (cmd_i == CMD_LOAD) sof_d = load_hi_i;
      else if (frame_edge)   sof_d = sof_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sof_q <= '0;
      else        sof_q <= sof_d;
   end

   assign sof_o = sof_q;

endmodule

// File: rtl/mfidx_readmux.sv
module mfidx_readmux #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned IDX_W = 14
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [REG_W-1:0] rdata_o
);

   if (REG_W > IDX_W) begin : g_pad
      assign rdata_o = {{(REG_W-IDX_W){1'b0}}, idx_i};
   end else begin : g_exact
      assign rdata_o = idx_i;
   end

endmodule

// File: rtl/mfidx_top.sv
module mfidx_top
   import mfidx_pkg::*;
#(
   parameter int unsigned REG_W = DEF_REG_W,
   parameter int unsigned IDX_W = DEF_IDX_W,
   parameter int unsigned SUB_W = DEF_SUB_W,
   localparam int unsigned BE_W   = REG_W / 8,
   localparam int unsigned SOF_W  = IDX_W - SUB_W,
   localparam int unsigned SLOT_W = IDX_W - SUB_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              run_i,
   input  logic              halted_i,
   input  logic              reg_wr_i,
   input  logic [BE_W-1:0]   reg_be_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic [IDX_W-1:0]  uf_idx_o,
   output logic [SLOT_W-1:0] list_slot_o,
   output logic [SOF_W-1:0]  sof_num_o
);

   if (IDX_W > REG_W) begin : g_bad_width
      $error("mfidx_top: index wider than register");
   end
   if (SUB_W < 1 || IDX_W < SUB_W + 2) begin : g_bad_sub
      $error("mfidx_top: sub-count width out of range");
   end
   if (REG_W % 8 != 0) begin : g_bad_reg
      $error("mfidx_top: register width must be whole bytes");
   end

   mf_cmd_e          cmd;
   logic [IDX_W-1:0] load_val;
   logic [IDX_W-1:0] idx;

   mfidx_ctl #(.REG_W(REG_W), .IDX_W(IDX_W)) u_ctl (
      .tick_i     (tick_i),
      .run_i      (run_i),
      .halted_i   (halted_i),
      .wr_i       (reg_wr_i),
      .be_i       (reg_be_i),
      .wdata_i    (reg_wdata_i),
      .cmd_o      (cmd),
      .load_val_o (load_val)
   );

   mfidx_index_ctr #(.IDX_W(IDX_W)) u_idx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd),
      .load_val_i (load_val),
      .idx_o      (idx)
   );

   mfidx_sof_shadow #(.IDX_W(IDX_W), .SUB_W(SUB_W)) u_sof (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (cmd),
      .idx_low_i (idx[SUB_W-1:0]),
      .load_hi_i (load_val[IDX_W-1:SUB_W]),
      .sof_o     (sof_num_o)
   );

   mfidx_readmux #(.REG_W(REG_W), .IDX_W(IDX_W)) u_rd (
      .idx_i   (idx),
      .rdata_o (reg_rdata_o)
   );

   assign uf_idx_o    = idx;
   assign list_slot_o = idx[IDX_W-2:SUB_W];

endmodule

// File: rtl/mfidx_chk.sv
module mfidx_chk #(
   parameter int unsigned IDX_W = 14,
   parameter int unsigned SUB_W = 3,
   parameter int unsigned BE_W  = 4,
   localparam int unsigned SOF_W = IDX_W - SUB_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             run,
   input logic             halted,
   input logic             wr,
   input logic [BE_W-1:0]  be,
   input logic [IDX_W-1:0] wlow,
   input logic [IDX_W-1:0] idx,
   input logic [SOF_W-1:0] sof
);

   logic adv;
   logic ld;
   assign adv = tick && run && !halted;
   assign ld  = wr && (&be) && halted && !run;

   assert_adv_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> idx == IDX_W'($past(idx) + 1'b1));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld) |=> ($stable(idx) && $stable(sof)));

   assert_load_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (idx == $past(wlow) && sof == $past(wlow[IDX_W-1:SUB_W])));

   assert_sof_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && idx[SUB_W-1:0] == '0) |=> sof == SOF_W'($past(sof) + 1'b1));

   assert_sof_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && idx[SUB_W-1:0] != '0) |=> $stable(sof));

   assert_partial_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !(&be) && !adv) |=> ($stable(idx) && $stable(sof)));

   assert_busy_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (run || !halted) && !adv) |=> ($stable(idx) && $stable(sof)));

endmodule

bind mfidx_top mfidx_chk #(.IDX_W(IDX_W), .SUB_W(SUB_W), .BE_W(BE_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick_i),
   .run    (run_i),
   .halted (halted_i),
   .wr     (reg_wr_i),
   .be     (reg_be_i),
   .wlow   (reg_wdata_i[IDX_W-1:0]),
   .idx    (uf_idx_o),
   .sof    (sof_num_o)
);

// File: tb/mfidx_top_tb.sv
module mfidx_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;

   // row: {tick, wr, run, halted, be[3:0], wdata[31:0], exp_idx[13:0], exp_sof[10:0]}
   localparam logic [64:0] VEC [0:NVEC-1] = '{
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h0001, 11'h001}, // R2 R5
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h0002, 11'h001}, // R2
      {1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0000_0123, 14'h0002, 11'h001}, // R7 running
      {1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0000_0321, 14'h0002, 11'h001}, // R7 not halted
      {1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'h0000_0000, 14'h0002, 11'h001}, // R10
      {1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0000_0ABD, 14'h0ABD, 11'h157}, // R6
      {1'b0, 1'b1, 1'b0, 1'b1, 4'h3, 32'h0000_0055, 14'h0ABD, 11'h157}, // R8
      {1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 32'hFFFF_C00A, 14'h000A, 11'h001}, // R9
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h000B, 11'h001}, // R2
      {1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0000_3FFE, 14'h3FFE, 11'h7FF}, // R6
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h3FFF, 11'h7FF}, // R5 hold
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h0000, 11'h7FF}, // R3 wrap
      {1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 32'h0000_0000, 14'h0001, 11'h000}  // R5 wrap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        run_i = 1'b0;
   logic        halted_i = 1'b1;
   logic        reg_wr_i = 1'b0;
   logic [3:0]  reg_be_i = 4'h0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic [13:0] uf_idx_o;
   logic [9:0]  list_slot_o;
   logic [10:0] sof_num_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mfidx_top u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .run_i       (run_i),
      .halted_i    (halted_i),
      .reg_wr_i    (reg_wr_i),
      .reg_be_i    (reg_be_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .uf_idx_o    (uf_idx_o),
      .list_slot_o (list_slot_o),
      .sof_num_o   (sof_num_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // full check of every view against an expected index and SOF number
   task automatic check_all(input string tag, input logic [13:0] ei, input logic [10:0] es);
      check({tag, " idx"}, {18'b0, uf_idx_o}, {18'b0, ei});
      check({tag, " sof"}, {21'b0, sof_num_o}, {21'b0, es});
      check({tag, " R4 slot"}, {22'b0, list_slot_o}, {22'b0, ei[12:3]});
      check({tag, " R9 rdata"}, reg_rdata_o, {18'b0, ei});
   endtask

   task automatic step(input logic t, input logic w, input logic r, input logic h,
                       input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      tick_i = t; reg_wr_i = w; run_i = r; halted_i = h;
      reg_be_i = be; reg_wdata_i = d;
      @(posedge clk);
      #1;
      tick_i = 1'b0; reg_wr_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [13:0] mi;
      logic [10:0] ms;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 in reset", 14'h0, 11'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][64], VEC[i][63], VEC[i][62], VEC[i][61], VEC[i][60:57], VEC[i][56:25]);
         check_all($sformatf("vec%0d", i), VEC[i][24:11], VEC[i][10:0]);
      end

      // R1: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_all("R1 async", 14'h0, 11'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: tick-only run from reset keeps the SOF number one microframe behind
      for (int n = 1; n <= 40; n++) begin
         step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0);
         mi = 14'(n);
         ms = mi[13:3] + ((mi[2:0] != 3'b000) ? 11'd1 : 11'd0);
         check_all("R11 lead", mi, ms);
      end

      // tick and write together while halted: write wins, tick dropped (R6 R10)
      step(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0000_0123);
      check_all("R6 collide halted", 14'h0123, 11'h024);
      step(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'h0);
      check_all("R10 tick halted", 14'h0123, 11'h024);

      // tick and write together while running: tick counts, write refused (R2 R7)
      step(1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0000_0555);
      check_all("R7 collide running", 14'h0124, 11'h024);

      // R4 R3 R5: slot runs out at the top and wraps with the index
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0000_3FF9);
      check_all("R4 top slot", 14'h3FF9, 11'h7FF);
      for (int n = 1; n <= 6; n++) begin
         step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0);
         check_all("R4 hold slot", 14'(14'h3FF9 + n), 11'h7FF);
      end
      step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0);
      check_all("R3 wrap", 14'h0000, 11'h7FF);
      step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0);
      check_all("R5 wrap", 14'h0001, 11'h000);

      finish_run();
   end

endmodule